// File: doc/BRIEF.md
# Halving Tree Sum Reducer

The block holds one partial sum per processor lane in a register bank and folds a chosen number of leading entries into a single total. Software or a preceding stage fills the bank through a one-entry-per-cycle write port, for example with each lane's local sum over its own slice of a larger array. It then pulses the start input with the number of participating entries.

Each clock cycle of a reduction performs one round. If the current length is odd, entry 0 first takes in the entry at index length−1. The length is then halved by integer division, and every lane below the new length adds in the entry at its own index plus the new length. All adds of a round read the bank as it stood before the round and commit together at the clock edge, so the edge is the barrier between rounds. When the length reaches 1, a one-cycle done pulse presents the total held in entry 0.

Sums are unsigned and wrap modulo 2^W. The block is intended as a hardware model of a tree reduction across processors.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset, busy and done are low, and every bank entry, and therefore result, is zero.
- R2: While idle, a write with wr_en high stores wr_data into entry wr_idx. A write whose wr_idx is at or above LANES changes no entry.
- R3: A start pulse while idle latches the effective length, and busy is high from the next cycle.
- R4: A reduction over effective length L takes R rounds of one cycle each, where R is the number of integer halvings that bring L down to 1. Done is high in the (R+1)-th cycle after the start cycle.
- R5: While done is high, result equals the sum modulo 2^W of bank entries 0 to L−1 as they stood when start was accepted.
- R6: Done is high for exactly one cycle, and busy is low in the cycle after done.
- R7: A start pulse while busy is ignored, and the running reduction continues with its own length.
- R8: Writes while busy are ignored and do not alter the total.
- R9: Additions wrap modulo 2^W without any overflow indication.
- R10: With an effective length of 1, no round is run, done is high in the cycle after the start cycle, and result equals entry 0.
- R11: A length of 0 is treated as 1, and a length above LANES is treated as LANES.
- R12: Entries at index L and above do not contribute to the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bank write strobe, honoured only while idle |
| wr_idx | input | $clog2(LANES) | Entry index for a write |
| wr_data | input | W | Value to store |
| start | input | 1 | Begin a reduction, honoured only while idle |
| len_in | input | $clog2(LANES+1) | Number of active entries, sampled with start |
| busy | output | 1 | Reduction in progress, done cycle included |
| done | output | 1 | One-cycle pulse, total valid on result |
| result | output | W | Bank entry 0 |

## Verification
The bench builds the block with 100 lanes and a 16-bit sum width. The lane count gives the odd-length chain 100, 50, 25, 12, 6, 3, 1, so the fold into entry 0 happens at two different depths. The narrow width makes the slice sums wrap, which puts modular addition (R9) within reach with ordinary data. The 7-bit length field can express 0 and values above 100, which exercises the clamping of R11.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;

   typedef enum logic {
      RS_IDLE = 1'b0,
      RS_RUN  = 1'b1
   } red_state_e;

endpackage

// File: rtl/tsr_round_ctrl.sv
module tsr_round_ctrl
   import tree_sum_pkg::*;
#(
   parameter int LANES = 100,
   parameter int LW    = $clog2(LANES + 1),
   parameter int RW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len_in,
   output logic          busy,
   output logic          done,
   output logic          adv,
   output logic [LW-1:0] len_q,
   output logic [LW-1:0] half,
   output logic          odd,
   output logic [RW-1:0] rounds_q
);

   red_state_e    st_q;
   logic [LW-1:0] len_eff;

   // Clamp the requested length into 1..LANES
   always_comb begin
      if (len_in == '0)
         len_eff = LW'(1);
      else if (len_in > LW'(LANES))
         len_eff = LW'(LANES);
      else
         len_eff = len_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= RS_IDLE;
         len_q    <= '0;
         rounds_q <= '0;
      end else begin
         unique case (st_q)
            RS_IDLE: begin
               if (start) begin
                  st_q     <= RS_RUN;
                  len_q    <= len_eff;
                  rounds_q <= '0;
               end
            end
            RS_RUN: begin
               if (len_q == LW'(1)) begin
                  st_q <= RS_IDLE;
               end else begin
                  len_q    <= len_q >> 1;
                  rounds_q <= rounds_q + RW'(1);
               end
            end
            default: st_q <= RS_IDLE;
         endcase
      end
   end

   assign busy = (st_q == RS_RUN);
   assign done = busy && (len_q == LW'(1));
   assign adv  = busy && (len_q != LW'(1));
   assign half = len_q >> 1;
   assign odd  = len_q[0];

endmodule

// File: rtl/tsr_lane_bank.sv
module tsr_lane_bank #(
   parameter int LANES = 100,
   parameter int W     = 32,
   parameter int IW    = $clog2(LANES),
   parameter int LW    = $clog2(LANES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic          adv,
   input  logic [LW-1:0] len_q,
   input  logic [LW-1:0] half,
   input  logic          odd,
   output logic [W-1:0]  head
);

   logic [LANES-1:0][W-1:0] ent;
   logic [LW-1:0]           tail_idx;

   assign tail_idx = len_q - LW'(1);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [W-1:0] q;
      logic [W-1:0] nxt;
      logic [LW:0]  pidx;
      logic         pair_on;
      logic         wr_hit;

      assign pidx    = {1'b0, half} + (LW + 1)'(i);
      assign pair_on = adv && (half > LW'(i));
      assign wr_hit  = wr_en && !busy && (wr_idx == IW'(i));

      if (i == 0) begin : g_head
         // Entry 0 also absorbs the orphan of an odd length
         logic [W-1:0] fold;
         assign fold = odd ? ent[tail_idx[IW-1:0]] : '0;
         assign nxt  = q + ent[pidx[IW-1:0]] + fold;
      end else begin : g_body
         logic [W-1:0] partner;
         assign partner = (pidx < (LW + 1)'(LANES)) ? ent[pidx[IW-1:0]] : '0;
         assign nxt     = q + partner;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (pair_on)
            q <= nxt;
         else if (wr_hit)
            q <= wr_data;
      end

      assign ent[i] = q;
   end

   assign head = ent[0];

endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer #(
   parameter int LANES = 100,
   parameter int W     = 32,
   parameter int IW    = $clog2(LANES),
   parameter int LW    = $clog2(LANES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic          start,
   input  logic [LW-1:0] len_in,
   output logic          busy,
   output logic          done,
   output logic [W-1:0]  result
);

   localparam int MAXR = $clog2(LANES);
   localparam int RW   = $clog2(MAXR + 1);

   if (LANES < 2) begin : g_chk_lanes
      $error("tree_sum_reducer: LANES must be at least 2");
   end
   if (W < 1) begin : g_chk_w
      $error("tree_sum_reducer: W must be at least 1");
   end

   logic          adv;
   logic          odd;
   logic [LW-1:0] len_q;
   logic [LW-1:0] half;
   logic [RW-1:0] rounds_q;

   tsr_round_ctrl #(
      .LANES (LANES),
      .LW    (LW),
      .RW    (RW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len_in   (len_in),
      .busy     (busy),
      .done     (done),
      .adv      (adv),
      .len_q    (len_q),
      .half     (half),
      .odd      (odd),
      .rounds_q (rounds_q)
   );

   tsr_lane_bank #(
      .LANES (LANES),
      .W     (W),
      .IW    (IW),
      .LW    (LW)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .adv     (adv),
      .len_q   (len_q),
      .half    (half),
      .odd     (odd),
      .head    (result)
   );

endmodule

// File: rtl/tree_sum_reducer_chk.sv
module tree_sum_reducer_chk #(
   parameter int LANES = 100,
   parameter int W     = 32,
   parameter int LW    = 7,
   parameter int RW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          wr_en,
   input logic          busy,
   input logic          done,
   input logic [W-1:0]  result,
   input logic [LW-1:0] len_q,
   input logic [RW-1:0] rounds_q
);

   localparam int MAXR = $clog2(LANES);

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);  // R3

   AST_ROUND_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (len_q == ($past(len_q) >> 1)));  // R4

   AST_ROUND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rounds_q <= RW'(MAXR)));  // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R6

   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);  // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && !done) |=> (busy && (len_q == ($past(len_q) >> 1))));  // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en) |=> $stable(result));  // R2

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((len_q >= LW'(1)) && (len_q <= LW'(LANES))));  // R11

endmodule

bind tree_sum_reducer tree_sum_reducer_chk #(
   .LANES (LANES),
   .W     (W),
   .LW    (LW),
   .RW    (RW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .wr_en    (wr_en),
   .busy     (busy),
   .done     (done),
   .result   (result),
   .len_q    (len_q),
   .rounds_q (rounds_q)
);

// File: tb/tree_sum_reducer_bench.sv
module tree_sum_reducer_bench;

   localparam int LANES = 100;
   localparam int W     = 16;
   localparam int IW    = $clog2(LANES);
   localparam int LW    = $clog2(LANES + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [W-1:0]  wr_data = '0;
   logic          start = 1'b0;
   logic [LW-1:0] len_in = '0;
   logic          busy;
   logic          done;
   logic [W-1:0]  result;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   tree_sum_reducer #(.LANES(LANES), .W(W)) u_tree_sum_reducer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .start(start), .len_in(len_in), .busy(busy), .done(done), .result(result)
   );

   // Behavioural reference model
   logic [W-1:0] m_bank [LANES];
   int           m_len = 0;
   bit           m_busy = 1'b0;

   function automatic int clamp_len(input int l);
      if (l == 0) return 1;
      if (l > LANES) return LANES;
      return l;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < LANES; k++) m_bank[k] = '0;
         m_busy = 1'b0;
         m_len  = 0;
      end else if (m_busy) begin
         if (m_len == 1) begin
            m_busy = 1'b0;
         end else begin
            logic [W-1:0] tmp [LANES];
            int h;
            tmp = m_bank;
            h = m_len / 2;
            if ((m_len % 2) != 0) tmp[0] = tmp[0] + m_bank[m_len-1];
            for (int k = 0; k < h; k++) tmp[k] = tmp[k] + m_bank[k+h];
            m_bank = tmp;
            m_len  = h;
         end
      end else begin
         if (wr_en && (int'(wr_idx) < LANES)) m_bank[int'(wr_idx)] = wr_data;
         if (start) begin
            m_len  = clamp_len(int'(len_in));
            m_busy = 1'b1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == m_busy, "R3", "busy vs model", busy, m_busy);
         chk(done == (m_busy && m_len == 1), "R6", "done vs model", done, (m_busy && m_len == 1));
         if (m_busy && m_len == 1)
            chk(result == m_bank[0], "R5", "result vs model", result, m_bank[0]);
      end
   end

   task automatic wr(input int idx, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = W'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_slices(input int salt);
      for (int i = 0; i < LANES; i++)
         wr(i, 1000 * 1000 * i + 499500 + salt * i);
   endtask

   task automatic run(input int l, input string tag, input bit poke);
      int lc, er, cyc, t;
      logic [W-1:0] exp;
      lc = clamp_len(l);
      er = 0; t = lc;
      while (t > 1) begin t = t / 2; er++; end
      @(negedge clk);
      exp = '0;
      for (int k = 0; k < lc; k++) exp = exp + m_bank[k];
      start = 1'b1; len_in = LW'(l);
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 40) begin
         if (poke && cyc == 2) begin
            start = 1'b1; len_in = LW'(3);                    // R7 stray start
            wr_en = 1'b1; wr_idx = '0; wr_data = 16'h1234;    // R8 stray write
         end
         @(negedge clk);
         start = 1'b0; wr_en = 1'b0;
         cyc++;
      end
      chk(cyc == er + 1, "R4", {tag, " cycles to done"}, cyc, er + 1);
      chk(result == exp, "R5", {tag, " total"}, result, exp);
      @(negedge clk);
      chk(!busy && !done, "R6", {tag, " idle after done"}, {busy, done}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R1", "flags after reset", {busy, done}, 0);
      chk(result == '0, "R1", "result after reset", result, 0);
      rst_n = 1'b1;

      load_slices(0);
      run(100, "R5 full length with R7 R8 pokes", 1'b1);

      load_slices(3);
      wr(0, 16'h0042);
      run(1, "R10 single entry", 1'b0);
      chk(result == 16'h0042, "R10", "single entry value", result, 16'h0042);

      load_slices(5);
      run(0, "R11 zero length", 1'b0);
      load_slices(7);
      run(120, "R11 oversize length", 1'b0);

      load_slices(9);
      run(7, "R12 odd prefix", 1'b0);
      load_slices(11);
      run(2, "R4 two entries", 1'b0);
      load_slices(13);
      run(3, "R4 three entries", 1'b0);

      load_slices(2);
      wr(110, 16'h7777);
      wr(5, 16'h0005);
      run(6, "R2 write port", 1'b0);

      for (int i = 0; i < LANES; i++) wr(i, 16'hFFFF);
      run(100, "R9 wrap", 1'b0);
      chk(result == 16'hFF9C, "R9", "wrapped total", result, 16'hFF9C);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog R4: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule